// File: doc/BRIEF.md
# Per-Pipeline Timing-Error Rate Monitor

Several floating-point pipelines are shared by a processor cluster. Each of them carries a group of timing-error sensor bits. This block watches those sensor groups and counts, for each pipeline, the cycles in which at least one of its sensor bits fired. The counting runs over a sampling window whose length software sets.

When a window closes, the block turns each count into an integer percentage of the window length and publishes it in a read-only register. The counters then restart at once for the next window. A run-time scheduler reads the published values, or a register that already names the pipeline with the lowest value, and sends work to the pipelines that err least. Software reaches the block through a simple register bus. A write takes effect at the clock edge, and a read returns data combinationally in the same cycle.

Register addresses: 0 holds the window length (read/write, bits PERIOD_W-1:0). Address 1 holds the index of the best pipeline (read-only). Address 2+i holds the percentage for pipeline i (read-only, 0..100).

Top module: `err_rate_monitor`

## Requirements
- R1: After reset, address 0 reads 0, every percentage register reads 0, and address 1 reads 0.
- R2: A cycle counts as an error cycle for pipeline i if any bit of that pipeline's sensor group is 1 in that cycle. Several set bits in one cycle count once.
- R3: P clock edges after the edge that wrote a non-zero length P, the register of each pipeline reads floor(error_cycles*100/P), taken over those P edges. The same holds P edges after each earlier window closed.
- R4: Each pipeline is counted and published on its own, and errors on one pipeline never change another pipeline's value.
- R5: Published values stay unchanged while a window is in progress, and are all replaced together when it closes. A new window starts by itself with no software action.
- R6: A write to address 0 discards the current partial window, including the sample at the write edge, and starts a new window of the written length.
- R7: Address 1 returns the index of the pipeline with the lowest published percentage. On a tie it returns the lowest such index.
- R8: A length of 0 disables measurement. Sensor activity is then ignored, and the published values keep their last contents.
- R9: Writes to any address other than 0 have no effect. Address 0 reads back the last length written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| sens_err | input | NUM_PIPES*SENS_W | Sensor bits; pipeline i owns bits [i*SENS_W +: SENS_W] |

## Verification
The hardest condition to reach from the ports is a window that ends early. A length write has to land in the middle of a window that has already gathered errors, and the discarded errors must not leak into the next window. The stimulus does this by starting a long window with every sensor firing, then rewriting a short length halfway through it. It then runs a clean short window and expects zero everywhere. Holding behaviour is reached in a similar way. The bench first builds a published state that is not all zero and has a tie. It then disables measurement and floods the sensors, so that any change would be visible.

// File: rtl/erm_pkg.sv
package erm_pkg;
    localparam int PCT_W        = 7;
    localparam int REG_PERIOD   = 0;
    localparam int REG_BEST     = 1;
    localparam int REG_PCT_BASE = 2;
endpackage

// File: rtl/erm_window_ctrl.sv
module erm_window_ctrl #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    input  logic                restart,
    output logic                active,
    output logic                win_end,
    output logic [PERIOD_W-1:0] cyc_q
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cyc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        active  = (period != '0);
        win_end = active && !restart && (st_q.cyc == period - PERIOD_W'(1));
        if (restart || !active || win_end) begin
            st_d.cyc = '0;
        end else begin
            st_d.cyc = st_q.cyc + PERIOD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cyc_q = st_q.cyc;
endmodule

// File: rtl/erm_pipe_counter.sv
module erm_pipe_counter
    import erm_pkg::*;
#(
    parameter int SENS_W   = 8,
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SENS_W-1:0]   sens,
    input  logic                active,
    input  logic                restart,
    input  logic                win_end,
    input  logic [PERIOD_W-1:0] period,
    output logic [PCT_W-1:0]    pct
);
    localparam int PROD_W = PERIOD_W + PCT_W;

    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
        logic [PCT_W-1:0]    pct;
    } st_t;

    st_t st_d, st_q;
    logic [PERIOD_W-1:0] total;
    logic [PROD_W-1:0]   prod;
    logic [PROD_W-1:0]   quot;
    logic [PERIOD_W-1:0] divisor;

    always_comb begin
        st_d    = st_q;
        total   = st_q.cnt + PERIOD_W'(|sens);
        divisor = (period == '0) ? PERIOD_W'(1) : period;
        prod    = PROD_W'(total) * PROD_W'(100);
        quot    = prod / PROD_W'(divisor);
        if (restart) begin
            st_d.cnt = '0;
        end else if (active) begin
            if (win_end) begin
                st_d.pct = quot[PCT_W-1:0];
                st_d.cnt = '0;
            end else begin
                st_d.cnt = total;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pct = st_q.pct;
endmodule

// File: rtl/erm_best_sel.sv
module erm_best_sel
    import erm_pkg::*;
#(
    parameter int NUM_PIPES = 4,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_PIPES*PCT_W-1:0] pct_flat,
    output logic [IDX_W-1:0]           best_idx
);
    logic [PCT_W-1:0] best_val;

    always_comb begin
        best_idx = '0;
        best_val = pct_flat[PCT_W-1:0];
        for (int i = 1; i < NUM_PIPES; i++) begin
            if (pct_flat[i*PCT_W +: PCT_W] < best_val) begin
                best_val = pct_flat[i*PCT_W +: PCT_W];
                best_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/err_rate_monitor.sv
module err_rate_monitor
    import erm_pkg::*;
#(
    parameter int NUM_PIPES = 4,
    parameter int SENS_W    = 8,
    parameter int PERIOD_W  = 16,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_PIPES*SENS_W-1:0] sens_err
);
    localparam int IDX_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1;

    typedef struct packed {
        logic [PERIOD_W-1:0] period;
    } regs_t;

    regs_t regs_d, regs_q;
    logic                       restart;
    logic                       active;
    logic                       win_end;
    logic [PERIOD_W-1:0]        win_cyc;
    logic [PERIOD_W-1:0]        period_q;
    logic [NUM_PIPES*PCT_W-1:0] pct_flat;
    logic [IDX_W-1:0]           best_idx;

    always_comb begin
        regs_d  = regs_q;
        restart = bus_wr && (bus_addr == ADDR_W'(REG_PERIOD));
        if (restart) regs_d.period = bus_wdata[PERIOD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign period_q = regs_q.period;

    erm_window_ctrl #(.PERIOD_W(PERIOD_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (period_q),
        .restart (restart),
        .active  (active),
        .win_end (win_end),
        .cyc_q   (win_cyc)
    );

    for (genvar g = 0; g < NUM_PIPES; g++) begin : g_pipe
        erm_pipe_counter #(.SENS_W(SENS_W), .PERIOD_W(PERIOD_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .sens    (sens_err[g*SENS_W +: SENS_W]),
            .active  (active),
            .restart (restart),
            .win_end (win_end),
            .period  (period_q),
            .pct     (pct_flat[g*PCT_W +: PCT_W])
        );
    end

    erm_best_sel #(.NUM_PIPES(NUM_PIPES), .IDX_W(IDX_W)) u_best (
        .pct_flat (pct_flat),
        .best_idx (best_idx)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_PERIOD)) bus_rdata = DATA_W'(period_q);
        if (bus_addr == ADDR_W'(REG_BEST))   bus_rdata = DATA_W'(best_idx);
        for (int i = 0; i < NUM_PIPES; i++) begin
            if (bus_addr == ADDR_W'(REG_PCT_BASE + i))
                bus_rdata = DATA_W'(pct_flat[i*PCT_W +: PCT_W]);
        end
    end
endmodule

// File: rtl/erm_checker.sv
module erm_checker
    import erm_pkg::*;
#(
    parameter int NUM_PIPES = 4,
    parameter int PERIOD_W  = 16,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [PERIOD_W-1:0]        period_q,
    input logic [PERIOD_W-1:0]        win_cyc,
    input logic                       win_end,
    input logic [NUM_PIPES*PCT_W-1:0] pct_flat,
    input logic [IDX_W-1:0]           best_idx
);
    logic pct_sel;
    always_comb begin
        pct_sel = 1'b0;
        for (int i = 0; i < NUM_PIPES; i++)
            if (bus_addr == ADDR_W'(REG_PCT_BASE + i)) pct_sel = 1'b1;
    end

    AST_PCT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pct_sel |-> (bus_rdata <= DATA_W'(100))); // R3
    AST_HOLD_MIDWINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(pct_flat)); // R5
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == '0) |-> !win_end); // R8
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(REG_PERIOD)) |=> (win_cyc == '0)); // R6
    AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != ADDR_W'(REG_PERIOD)) |=> $stable(period_q)); // R9
    AST_BEST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(best_idx) < NUM_PIPES); // R7

    for (genvar g = 0; g < NUM_PIPES; g++) begin : g_min
        AST_BEST_MIN: assert property (@(posedge clk) disable iff (!rst_n)
            pct_flat[g*PCT_W +: PCT_W] >= pct_flat[int'(best_idx)*PCT_W +: PCT_W]); // R7
    end
endmodule

bind err_rate_monitor erm_checker #(
    .NUM_PIPES (NUM_PIPES),
    .PERIOD_W  (PERIOD_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W)
) u_erm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .period_q  (period_q),
    .win_cyc   (win_cyc),
    .win_end   (win_end),
    .pct_flat  (pct_flat),
    .best_idx  (best_idx)
);

// File: tb/tb_err_rate_monitor.sv
module tb_err_rate_monitor;
    localparam int NP = 4;
    localparam int SW = 8;
    localparam int PW = 16;
    localparam int AW = 4;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [NP*SW-1:0] sens_err = '0;

    int checks = 0;
    int errors = 0;
    int hits [NP];
    bit mon_busy = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int    addr;
        int    exp;
        string tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    err_rate_monitor #(.NUM_PIPES(NP), .SENS_W(SW), .PERIOD_W(PW),
                       .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sens_err(sens_err));

    // monitor: pops expected items and compares the read data
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            mon_busy = 1'b1;
            begin
                item_t it;
                it = sb_q.pop_front();
                bus_addr = AW'(it.addr);
                #1;
                checks++;
                if (bus_rdata !== DW'(it.exp)) begin
                    errors++;
                    $display("FAIL %s addr=%0d actual=%0d expected=%0d",
                             it.tag, it.addr, bus_rdata, it.exp);
                end
            end
            mon_busy = 1'b0;
        end
    end

    task automatic push(input int addr, input int exp, input string tag);
        item_t it;
        it.addr = addr; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    function automatic logic [SW-1:0] pattern(input int mode, input int p, input int c);
        case (mode)
            1: case (p)
                   0: return SW'(1);
                   2: return (c < 3) ? '1 : '0;
                   3: return (c % 2 == 0) ? SW'(32) : '0;
                   default: return '0;
               endcase
            2: return (p == 1) ? SW'(4) : '0;
            3: return (p < 3 && c <= p) ? SW'(1 << p) : '0;
            4: return '1;
            6: return (p < 2) ? '1 : '0;
            default: return '0;
        endcase
    endfunction

    task automatic clear_hits();
        for (int p = 0; p < NP; p++) hits[p] = 0;
    endtask

    // called at a negedge; leaves at a negedge
    task automatic bus_write(input int addr, input int data);
        sens_err = '0;
        bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = DW'(data);
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic run(input int mode, input int n, input int c0);
        for (int c = c0; c < c0 + n; c++) begin
            for (int p = 0; p < NP; p++) begin
                sens_err[p*SW +: SW] = pattern(mode, p, c);
                if (pattern(mode, p, c) != '0) hits[p]++;
            end
            @(posedge clk); @(negedge clk);
        end
        sens_err = '0;
    endtask

    task automatic expect_pcts(input int period, input string tag);
        for (int p = 0; p < NP; p++) push(2 + p, hits[p] * 100 / period, tag);
        drain();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        push(0, 0, "R1 period");
        push(1, 0, "R1 best");
        for (int p = 0; p < NP; p++) push(2 + p, 0, "R1 pct");
        drain();

        // R2 R3 R4: mixed window, multi-bit cycles counted once
        bus_write(0, 10);
        clear_hits();
        run(1, 10, 0);
        expect_pcts(10, "R2_R3_R4 window");
        push(0, 10, "R9 period readback");
        push(1, 1, "R7 best");
        drain();

        // R5: values hold mid-window, auto restart
        clear_hits();
        run(2, 5, 0);
        push(2, 100, "R5 hold p0");
        push(3, 0, "R5 hold p1");
        push(4, 30, "R5 hold p2");
        push(5, 50, "R5 hold p3");
        drain();
        run(2, 5, 5);
        expect_pcts(10, "R5 next window");
        push(1, 0, "R7 tie at zero");
        drain();

        // R3: floor rounding with period 7
        bus_write(0, 7);
        clear_hits();
        run(3, 7, 0);
        push(2, 14, "R3 floor p0");
        push(3, 28, "R3 floor p1");
        push(4, 42, "R3 floor p2");
        push(5, 0, "R3 floor p3");
        push(1, 3, "R7 best");
        drain();

        // R6: rewrite period mid-window discards partial counts
        bus_write(0, 10);
        clear_hits();
        run(4, 5, 0);
        bus_write(0, 4);
        clear_hits();
        run(5, 4, 0);
        expect_pcts(4, "R6 discarded");
        push(1, 0, "R6 best");
        drain();

        // R7: tie between pipes 2 and 3
        clear_hits();
        run(6, 4, 0);
        expect_pcts(4, "R7 tie window");
        push(1, 2, "R7 tie lower index");
        drain();

        // R8: disable and flood sensors
        bus_write(0, 0);
        run(4, 20, 0);
        push(2, 100, "R8 hold p0");
        push(3, 100, "R8 hold p1");
        push(4, 0, "R8 hold p2");
        push(5, 0, "R8 hold p3");
        push(0, 0, "R8 period");
        drain();

        // R9: writes to read-only registers ignored
        bus_write(4, 55);
        bus_write(1, 3);
        push(4, 0, "R9 pct unchanged");
        push(1, 2, "R9 best unchanged");
        push(0, 0, "R9 period unchanged");
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule